// File: doc/BRIEF.md
# External interrupt flag controller

This block keeps the eight-bit timer and external-interrupt control register of an 8051-style microcontroller core. It watches two active-low external request pins, each configurable to raise a request on a falling edge or while held low. It also holds two timer overflow flags and two timer run enables. The timers, priority resolution and vector generation live elsewhere. This block only produces the request flags and the run enables, and accepts the overflow pulses and the acknowledge strobes that mark a service routine being vectored to.

Software reaches the register through a small bus. That bus supports a whole-byte write, a single-bit set/clear and a combinational read. The pins are raw asynchronous inputs and are synchronized inside the block.

Each flag is a small two-state machine. An overflow flag moves between OV_CLEAR and OV_SET. The transition OV_CLEAR to OV_SET happens on an overflow pulse. The transition OV_SET to OV_CLEAR happens on an acknowledge with no pulse in the same cycle. A software write forces either state. An external channel moves between XS_IDLE and XS_PEND. The transition XS_IDLE to XS_PEND happens on a detected falling edge in edge mode. The transition XS_PEND to XS_IDLE happens on an acknowledge with no new edge in the same cycle. A software write forces either state. Level mode forces XS_IDLE.

Top module: `xirq_ctrl_reg`

## Requirements
- R1: After reset, the register reads 8'h00 and every flag and run output is 0.
- R2: The register answers at bus address 8'h88. Its bit layout, from bit 7 to bit 0, is: overflow flag 1, run 1, overflow flag 0, run 0, external flag 1, mode 1, external flag 0, mode 0. A read at any other address returns 8'h00, and a write at any other address changes nothing.
- R3: A whole-byte write (bus_wr) loads all eight bits. A bit operation (bus_bit_wr) loads bus_bit_val into the bit numbered bus_bit_sel and leaves the other bits unchanged. When both are asserted together, the whole-byte write is used.
- R4: An overflow pulse on tmr_ovf[c] sets overflow flag c at the next clock edge.
- R5: An acknowledge on ack_tmr[c] clears overflow flag c at the next clock edge. If a pulse arrives in the same cycle, the flag is set instead.
- R6: The run bits change only through software writes and drive tmr_run.
- R7: Each pin passes through two synchronizer flops and one history flop. A falling edge is recognized when the history flop holds 1 and the second synchronizer flop holds 0. The edge-mode flag therefore rises at the third clock edge after the pin falls.
- R8: In edge mode (mode bit 1), an external flag stays set after a falling edge until ack_ext[c] clears it. A new edge in the same cycle as the acknowledge keeps the flag set.
- R9: In level mode (mode bit 0), an external flag equals the inverted second synchronizer flop, so it follows the pin two edges late. The acknowledge and software writes to the flag bit have no effect in this mode.
- R10: A software write to a flag bit takes precedence over a hardware set and over an acknowledge in the same cycle.
- R11: Switching a channel to level mode discards any latched edge request. After switching back to edge mode, the flag starts cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Whole-byte write strobe |
| bus_wdata | input | 8 | Whole-byte write data |
| bus_bit_wr | input | 1 | Single-bit write strobe |
| bus_bit_sel | input | 3 | Bit index for single-bit write |
| bus_bit_val | input | 1 | Value for single-bit write |
| rd_data | output | 8 | Combinational read data |
| ext_pin_n | input | 2 | Raw active-low external request pins |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ack_tmr | input | 2 | Timer vector acknowledge strobes |
| ack_ext | input | 2 | External vector acknowledge strobes |
| ovf_flag | output | 2 | Timer overflow flags |
| ext_req | output | 2 | External request flags |
| tmr_run | output | 2 | Timer run enables |

## Verification
Long random runs drive slowly toggling pins, sparse overflow pulses and acknowledges, and occasional writes at both the register address and stray addresses. Running these in both modes separates sticky edge capture from plain level following. Directed cases place an acknowledge on the same cycle as an edge or an overflow pulse, which shows that a hardware set beats a clear. They also place a software write against both. A separate case flips a channel from edge to level mode and back, which shows whether a latched request survives a mode change.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int unsigned REG_W  = 8;
    localparam int unsigned N_CH   = 2;
    localparam int unsigned SEL_W  = $clog2(REG_W);

    // bit position helpers (layout is decoded by software)
    function automatic int unsigned pos_ovf(input int unsigned c);
        return 5 + 2 * c;
    endfunction
    function automatic int unsigned pos_run(input int unsigned c);
        return 4 + 2 * c;
    endfunction
    function automatic int unsigned pos_xf(input int unsigned c);
        return 1 + 2 * c;
    endfunction
    function automatic int unsigned pos_xm(input int unsigned c);
        return 2 * c;
    endfunction

    typedef enum logic {XS_IDLE, XS_PEND} xstate_t;
    typedef enum logic {OV_CLEAR, OV_SET} ovstate_t;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic pin_s,
    output logic pin_hist
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[i] <= 1'b1;
                end else if (i == 0) begin
                    chain_q[i] <= pin_n;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_hist <= 1'b1;
        end else begin
            pin_hist <= chain_q[STAGES-1];
        end
    end

    assign pin_s = chain_q[STAGES-1];

    AST_HIST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pin_hist == $past(pin_s)); // R7
endmodule

// File: rtl/xirq_ovf_chan.sv
module xirq_ovf_chan
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_pulse,
    input  logic ack,
    input  logic sw_we,
    input  logic sw_val,
    output logic flag
);
    ovstate_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OV_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (sw_we) begin
            state_d = sw_val ? OV_SET : OV_CLEAR;
        end else begin
            unique case (state_q)
                OV_CLEAR: if (ovf_pulse) state_d = OV_SET;
                OV_SET:   if (ack && !ovf_pulse) state_d = OV_CLEAR;
                default:  state_d = OV_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag = (state_q == OV_SET);
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_pulse && !sw_we) |=> flag); // R4
    AST_OVF_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !ovf_pulse && !sw_we) |=> !flag); // R5
    AST_OVF_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> flag == $past(sw_val)); // R10
endmodule

// File: rtl/xirq_ext_chan.sv
module xirq_ext_chan
    import xirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic edge_mode,
    input  logic pin_s,
    input  logic pin_hist,
    input  logic ack,
    input  logic sw_we,
    input  logic sw_val,
    output logic flag
);
    xstate_t state_q, state_d;
    logic    fall;

    assign fall = pin_hist & ~pin_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (!edge_mode) begin
            state_d = XS_IDLE;
        end else if (sw_we) begin
            state_d = sw_val ? XS_PEND : XS_IDLE;
        end else begin
            unique case (state_q)
                XS_IDLE: if (fall) state_d = XS_PEND;
                XS_PEND: if (ack && !fall) state_d = XS_IDLE;
                default: state_d = XS_IDLE;
            endcase
        end
    end

    always_comb begin
        flag = edge_mode ? (state_q == XS_PEND) : ~pin_s;
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall && !sw_we) |=> (flag || !edge_mode)); // R8
    AST_EDGE_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !fall && !sw_we) |=> (!flag || !edge_mode)); // R8
    AST_EDGE_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && sw_we) |=> (flag == $past(sw_val) || !edge_mode)); // R10
    AST_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode) |=> (!flag || !edge_mode)); // R11
endmodule

// File: rtl/xirq_ctrl_reg.sv
module xirq_ctrl_reg
    import xirq_pkg::*;
#(
    parameter int unsigned ADDR_W      = 8,
    parameter logic [7:0]  REG_ADDR    = 8'h88,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_bit_wr,
    input  logic [2:0]        bus_bit_sel,
    input  logic              bus_bit_val,
    output logic [7:0]        rd_data,
    input  logic [1:0]        ext_pin_n,
    input  logic [1:0]        tmr_ovf,
    input  logic [1:0]        ack_tmr,
    input  logic [1:0]        ack_ext,
    output logic [1:0]        ovf_flag,
    output logic [1:0]        ext_req,
    output logic [1:0]        tmr_run
);
    logic             hit;
    logic             full_we;
    logic             bit_we;
    logic [REG_W-1:0] we_mask;
    logic [REG_W-1:0] we_val;
    logic [REG_W-1:0] reg_view;
    logic [N_CH-1:0]  mode_q;
    logic [N_CH-1:0]  run_q;
    logic [N_CH-1:0]  pin_s;
    logic [N_CH-1:0]  pin_hist;

    assign hit     = (bus_addr == ADDR_W'(REG_ADDR));
    assign full_we = hit && bus_wr;
    assign bit_we  = hit && bus_bit_wr && !bus_wr;

    always_comb begin
        we_mask = '0;
        we_val  = {REG_W{bus_bit_val}};
        if (full_we) begin
            we_mask = '1;
            we_val  = bus_wdata;
        end else if (bit_we) begin
            we_mask[bus_bit_sel] = 1'b1;
        end
    end

    generate
        for (genvar c = 0; c < N_CH; c++) begin : g_ch
            localparam int unsigned P_OVF = pos_ovf(c);
            localparam int unsigned P_RUN = pos_run(c);
            localparam int unsigned P_XF  = pos_xf(c);
            localparam int unsigned P_XM  = pos_xm(c);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    mode_q[c] <= 1'b0;
                    run_q[c]  <= 1'b0;
                end else begin
                    if (we_mask[P_XM])  mode_q[c] <= we_val[P_XM];
                    if (we_mask[P_RUN]) run_q[c]  <= we_val[P_RUN];
                end
            end

            xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_n    (ext_pin_n[c]),
                .pin_s    (pin_s[c]),
                .pin_hist (pin_hist[c])
            );

            xirq_ext_chan u_ext (
                .clk       (clk),
                .rst_n     (rst_n),
                .edge_mode (mode_q[c]),
                .pin_s     (pin_s[c]),
                .pin_hist  (pin_hist[c]),
                .ack       (ack_ext[c]),
                .sw_we     (we_mask[P_XF]),
                .sw_val    (we_val[P_XF]),
                .flag      (ext_req[c])
            );

            xirq_ovf_chan u_ovf (
                .clk       (clk),
                .rst_n     (rst_n),
                .ovf_pulse (tmr_ovf[c]),
                .ack       (ack_tmr[c]),
                .sw_we     (we_mask[P_OVF]),
                .sw_val    (we_val[P_OVF]),
                .flag      (ovf_flag[c])
            );

            assign reg_view[P_OVF] = ovf_flag[c];
            assign reg_view[P_RUN] = run_q[c];
            assign reg_view[P_XF]  = ext_req[c];
            assign reg_view[P_XM]  = mode_q[c];
        end
    endgenerate

    assign tmr_run = run_q;
    assign rd_data = hit ? reg_view : 8'h00;

    AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_we || bit_we) |=> $stable(tmr_run)); // R6
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_we || bit_we) |=> $stable(mode_q)); // R2
    AST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we && bus_bit_sel != 3'd6 && bus_bit_sel != 3'd4) |=> $stable(tmr_run)); // R3
endmodule

// File: tb/xirq_ctrl_reg_bench.sv
module xirq_ctrl_reg_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_bit_wr = 1'b0;
    logic [2:0] bus_bit_sel = 3'd0;
    logic       bus_bit_val = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] ext_pin_n = 2'b11;
    logic [1:0] tmr_ovf = 2'b00;
    logic [1:0] ack_tmr = 2'b00;
    logic [1:0] ack_ext = 2'b00;
    logic [1:0] ovf_flag;
    logic [1:0] ext_req;
    logic [1:0] tmr_run;

    int n_tests = 0;
    int n_fail  = 0;

    // requirement model
    logic [1:0] m_s1, m_s2, m_h, m_q, m_mode, m_run, m_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    xirq_ctrl_reg u_xirq_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_bit_wr(bus_bit_wr), .bus_bit_sel(bus_bit_sel),
        .bus_bit_val(bus_bit_val), .rd_data(rd_data), .ext_pin_n(ext_pin_n),
        .tmr_ovf(tmr_ovf), .ack_tmr(ack_tmr), .ack_ext(ack_ext),
        .ovf_flag(ovf_flag), .ext_req(ext_req), .tmr_run(tmr_run)
    );

    function automatic logic [1:0] exp_ext();
        logic [1:0] r;
        for (int c = 0; c < 2; c++) r[c] = m_mode[c] ? m_q[c] : ~m_s2[c];
        return r;
    endfunction

    function automatic logic [7:0] exp_reg();
        logic [1:0] x;
        x = exp_ext();
        return {m_ovf[1], m_run[1], m_ovf[0], m_run[0], x[1], m_mode[1], x[0], m_mode[0]};
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_s1 = 2'b11; m_s2 = 2'b11; m_h = 2'b11;
        m_q = 0; m_mode = 0; m_run = 0; m_ovf = 0;
    endtask

    task automatic compare_all();
        check("R4 R5 ovf_flag", {6'd0, ovf_flag}, {6'd0, m_ovf});
        check("R6 tmr_run", {6'd0, tmr_run}, {6'd0, m_run});
        check("R7 R8 R9 ext_req", {6'd0, ext_req}, {6'd0, exp_ext()});
        check("R2 rd_data", rd_data, (bus_addr == 8'h88) ? exp_reg() : 8'h00);
    endtask

    // advance one clock with current inputs, update the model, then compare
    task automatic step();
        logic [7:0] mask, wv;
        logic [1:0] n_q, n_ovf, n_run, n_mode, fall;
        logic hit;
        hit  = (bus_addr == 8'h88);
        mask = 8'h00;
        wv   = {8{bus_bit_val}};
        if (hit && bus_wr) begin
            mask = 8'hFF; wv = bus_wdata;
        end else if (hit && bus_bit_wr) begin
            mask = 8'h01 << bus_bit_sel;
        end
        fall = m_h & ~m_s2;
        for (int c = 0; c < 2; c++) begin
            int po, pr, pf, pm;
            po = 5 + 2*c; pr = 4 + 2*c; pf = 1 + 2*c; pm = 2*c;
            n_ovf[c]  = mask[po] ? wv[po] : (tmr_ovf[c] ? 1'b1 : (ack_tmr[c] ? 1'b0 : m_ovf[c]));
            n_run[c]  = mask[pr] ? wv[pr] : m_run[c];
            n_mode[c] = mask[pm] ? wv[pm] : m_mode[c];
            if (!m_mode[c]) n_q[c] = 1'b0;
            else n_q[c] = mask[pf] ? wv[pf] : (fall[c] ? 1'b1 : (ack_ext[c] ? 1'b0 : m_q[c]));
        end
        @(posedge clk);
        m_h = m_s2; m_s2 = m_s1; m_s1 = ext_pin_n;
        m_q = n_q; m_ovf = n_ovf; m_run = n_run; m_mode = n_mode;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle_inputs();
        bus_wr = 0; bus_bit_wr = 0; tmr_ovf = 0; ack_tmr = 0; ack_ext = 0;
        bus_addr = 8'h88;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        idle_inputs(); bus_wr = 1; bus_wdata = d; step(); bus_wr = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int unsigned r;
        r = $urandom(32'h5EED_0451);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 8'h88;
        #1;
        // R1: reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 outputs", {2'b0, ovf_flag, ext_req, tmr_run}, 8'h00);

        // R3: bit op sets only run1 (bit 6)
        idle_inputs(); bus_bit_wr = 1; bus_bit_sel = 3'd6; bus_bit_val = 1; step();
        idle_inputs();
        check("R3 bit op", rd_data, 8'h40);
        // R3: byte write wins over bit op
        bus_wr = 1; bus_wdata = 8'h10; bus_bit_wr = 1; bus_bit_sel = 3'd7; bus_bit_val = 1; step();
        idle_inputs();
        check("R3 byte wins", rd_data, 8'h10);
        // R2: write at other address ignored, read there returns 0
        bus_addr = 8'h89; bus_wr = 1; bus_wdata = 8'hFF; step();
        check("R2 miss read", rd_data, 8'h00);
        idle_inputs(); #1;
        check("R2 miss write", rd_data, 8'h10);

        // R5: pulse and ack together -> set
        tmr_ovf = 2'b01; ack_tmr = 2'b01; step(); idle_inputs();
        check("R5 set beats ack", {6'd0, ovf_flag}, 8'h01);
        // R10: software clears ovf0 while pulse arrives
        bus_bit_wr = 1; bus_bit_sel = 3'd5; bus_bit_val = 0; tmr_ovf = 2'b01; step(); idle_inputs();
        check("R10 sw beats set", {6'd0, ovf_flag}, 8'h00);

        // R7 R8: edge mode on channel 0, falling edge latency
        wr_byte(8'h01);
        ext_pin_n = 2'b10; step(); step();
        check("R7 not yet", {6'd0, ext_req}, 8'h00);
        step();
        check("R7 edge seen", {6'd0, ext_req}, 8'h01);
        ext_pin_n = 2'b11; repeat (3) step();
        check("R8 sticky", {6'd0, ext_req}, 8'h01);
        // R11: to level mode drops latch, back to edge stays cleared
        wr_byte(8'h00); wr_byte(8'h01); idle_inputs(); #1;
        check("R11 latch dropped", {6'd0, ext_req}, 8'h00);
        // R9: level mode ack no effect
        wr_byte(8'h00);
        ext_pin_n = 2'b10; step(); step();
        ack_ext = 2'b01; step(); ack_ext = 0;
        check("R9 level follows", {6'd0, ext_req}, 8'h01);
        bus_bit_wr = 1; bus_bit_sel = 3'd1; bus_bit_val = 0; step(); idle_inputs();
        check("R9 write ignored", {6'd0, ext_req}, 8'h01);
        ext_pin_n = 2'b11; repeat (3) step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            idle_inputs();
            if ($urandom_range(7) == 0) ext_pin_n[0] = ~ext_pin_n[0];
            if ($urandom_range(7) == 0) ext_pin_n[1] = ~ext_pin_n[1];
            tmr_ovf = {$urandom_range(7) == 0, $urandom_range(7) == 0};
            ack_tmr = {$urandom_range(3) == 0, $urandom_range(3) == 0};
            ack_ext = {$urandom_range(3) == 0, $urandom_range(3) == 0};
            bus_addr = ($urandom_range(3) == 0) ? 8'($urandom) : 8'h88;
            if ($urandom_range(15) == 0) begin
                bus_wr = 1; bus_wdata = 8'($urandom);
            end
            if ($urandom_range(15) == 0) begin
                bus_bit_wr = 1; bus_bit_sel = 3'($urandom); bus_bit_val = 1'($urandom);
            end
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule